// File: doc/BRIEF.md
# Proximity Sensor Burst Drive Controller

This block runs a pulsed infrared proximity sensor from the host side. It releases the sensor from power-down and waits a settling delay. It then drives fixed-length bursts of emitter pulses on a long repeat period. At the end of each burst it samples the sensor's active-low detect line and records the result in a registered presence flag. A one-cycle strobe marks the moment the flag is refreshed.

A software enable gates the whole sequence. Dropping it aborts any burst at once and powers the sensor down. Raising it again starts the settling delay from zero. An independent watchdog watches the emitter output. If any single high pulse grows as long as a parameterised limit, the watchdog cuts the pulse and latches a fault. The fault holds the sensor in power-down until software clears it.

All timing is given in microseconds and converted to clock cycles from a clock-frequency parameter. The detect input crosses into the clock domain through a synchroniser chain whose depth is a parameter.

Top module: `prox_burst_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sensor_sd` is 1 and `emit`, `present`, `burst_done` and `fault` are all 0.
- R2: While `en` is 0, `sensor_sd` stays 1 and `emit` stays 0. When `en` is 1 and `fault` is 0, `sensor_sd` falls one cycle later. The first `emit` high then begins exactly SETTLE_US x (CLK_HZ/1e6) cycles after `sensor_sd` fell, and SETTLE_US must be at least 20.
- R3: A burst is PULSES emitter pulses. Each pulse is high for HIGH_US worth of cycles, and consecutive pulses in a burst are separated by (PERIOD_US - HIGH_US) worth of low cycles.
- R4: Within one enabled session, the first rising edge of `emit` in a burst follows the first rising edge of the previous burst by exactly INTERVAL_US worth of cycles.
- R5: One cycle after `emit` falls at the end of the last pulse of a burst, `burst_done` is high for exactly one cycle. In that same cycle `present` takes the inverse of the synchronised `det_n` (`det_n` = 0 gives `present` = 1). `present` changes in no other cycle.
- R6: If `en` is 0 at a clock edge, the next cycle shows `sensor_sd` = 1 and `emit` = 0, and any burst in progress is abandoned. A later enable repeats the full settling delay of R2 and starts a fresh burst from its first pulse.
- R7: If `emit` has been high for WDOG_US worth of consecutive cycles, the next cycle shows `emit` = 0, `fault` = 1 and `sensor_sd` = 1. Pulses shorter than that limit never set `fault`. WDOG_US must be below 85.
- R8: While `fault` is 1, `sensor_sd` stays 1 and `emit` stays 0 regardless of `en`. A one-cycle `fault_clr` pulse gives `fault` = 0 in the next cycle. With `en` held at 1, `sensor_sd` then falls one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Software enable for the burst sequence |
| fault_clr | input | 1 | One-cycle pulse that clears the watchdog fault |
| det_n | input | 1 | Sensor detect line, low when an object is within range |
| sensor_sd | output | 1 | Sensor power-down, 1 = powered down, 0 = operating |
| emit | output | 1 | Emitter pulse drive |
| present | output | 1 | Registered presence result of the last completed burst |
| burst_done | output | 1 | One-cycle strobe when `present` is refreshed |
| fault | output | 1 | Sticky watchdog fault |

## Verification
The main configuration runs many bursts in a row. Before each burst ends, the detect line receives random values, including toggles in the middle of the burst, and is then left at a random final level. This shows that only the level present at the end of the burst reaches the presence flag, and that the flag holds between bursts. Enable is dropped at random points inside pulses and then restored after random delays. This separates a controller that restarts the settle delay and pulse count from one that resumes where it stopped. A second configuration with pulses longer than the watchdog limit exercises the cut-off width, the sticky shutdown with enable held high, and the release after a clear pulse.

// File: rtl/prox_burst_pkg.sv
package prox_burst_pkg;

   typedef enum logic [2:0] {
      PS_OFF    = 3'd0,
      PS_SETTLE = 3'd1,
      PS_HIGH   = 3'd2,
      PS_LOW    = 3'd3,
      PS_GAP    = 3'd4
   } prox_phase_t;

   function automatic int unsigned us_to_cycles(input int unsigned us,
                                                input int unsigned clk_hz);
      return us * (clk_hz / 32'd1_000_000);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prox_det_sync.sv
module prox_det_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("prox_det_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/prox_pulse_wdog.sv
module prox_pulse_wdog #(
   parameter int unsigned LIMIT_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic emit_i,
   input  logic clr_i,
   output logic trip_o,
   output logic fault_o
);

   if (LIMIT_CYC < 1) begin : g_bad_limit
      $error("prox_pulse_wdog: LIMIT_CYC must be at least 1");
   end

   localparam int unsigned WW = $clog2(LIMIT_CYC + 1);
   localparam logic [WW-1:0] LAST_OK = WW'(LIMIT_CYC - 1);
   localparam logic [WW-1:0] SAT     = WW'(LIMIT_CYC);

   logic [WW-1:0] hi_cnt;
   logic          fault_q;

   // trip on the cycle that completes LIMIT_CYC consecutive high cycles
   assign trip_o  = emit_i && (hi_cnt == LAST_OK);
   assign fault_o = fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hi_cnt <= '0;
      else if (!emit_i)        hi_cnt <= '0;
      else if (hi_cnt != SAT)  hi_cnt <= hi_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fault_q <= 1'b0;
      else if (trip_o)  fault_q <= 1'b1;
      else if (clr_i)   fault_q <= 1'b0;
   end

   AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> $past(emit_i)); // R7

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !clr_i && !trip_o) |=> fault_o); // R8

   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !trip_o) |=> !fault_o); // R8

endmodule

// File: rtl/prox_burst_seq.sv
module prox_burst_seq
   import prox_burst_pkg::*;
#(
   parameter int unsigned SET_C  = 25,
   parameter int unsigned HI_C   = 5,
   parameter int unsigned LO_C   = 5,
   parameter int unsigned GAP_C  = 65,
   parameter int unsigned PULSES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic fault_i,
   input  logic trip_i,
   output logic sd_o,
   output logic emit_o,
   output logic sample_o
);

   if (SET_C < 1 || HI_C < 1 || LO_C < 1 || GAP_C < 1) begin : g_bad_phase
      $error("prox_burst_seq: every phase needs at least one cycle");
   end
   if (PULSES < 1) begin : g_bad_pulses
      $error("prox_burst_seq: PULSES must be at least 1");
   end

   localparam int unsigned MAXC = max2(max2(SET_C, HI_C), max2(LO_C, GAP_C));
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam int unsigned PW   = (PULSES > 1) ? $clog2(PULSES) : 1;

   localparam logic [CW-1:0] SET_END = CW'(SET_C - 1);
   localparam logic [CW-1:0] HI_END  = CW'(HI_C - 1);
   localparam logic [CW-1:0] LO_END  = CW'(LO_C - 1);
   localparam logic [CW-1:0] GAP_END = CW'(GAP_C - 1);

   prox_phase_t   phase_q, phase_d;
   logic [CW-1:0] cnt_q,   cnt_d;
   logic [PW-1:0] pidx_q,  pidx_d;
   logic          last_pulse;

   // a single-pulse burst needs no pulse index compare
   if (PULSES == 1) begin : g_single
      assign last_pulse = 1'b1;
   end else begin : g_multi
      localparam logic [PW-1:0] P_END = PW'(PULSES - 1);
      assign last_pulse = (pidx_q == P_END);
   end

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q + 1'b1;
      pidx_d  = pidx_q;
      unique case (phase_q)
         PS_OFF: begin
            cnt_d = '0;
            if (en_i && !fault_i) phase_d = PS_SETTLE;
         end
         PS_SETTLE: begin
            if (cnt_q == SET_END) begin
               phase_d = PS_HIGH;
               cnt_d   = '0;
               pidx_d  = '0;
            end
         end
         PS_HIGH: begin
            if (cnt_q == HI_END) begin
               cnt_d   = '0;
               phase_d = last_pulse ? PS_GAP : PS_LOW;
            end
         end
         PS_LOW: begin
            if (cnt_q == LO_END) begin
               phase_d = PS_HIGH;
               cnt_d   = '0;
               pidx_d  = pidx_q + 1'b1;
            end
         end
         PS_GAP: begin
            if (cnt_q == GAP_END) begin
               phase_d = PS_HIGH;
               cnt_d   = '0;
               pidx_d  = '0;
            end
         end
         default: begin
            phase_d = PS_OFF;
            cnt_d   = '0;
         end
      endcase
      // disable, a watchdog trip or a held fault all force power-down
      if (!en_i || trip_i || fault_i) begin
         phase_d = PS_OFF;
         cnt_d   = '0;
         pidx_d  = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PS_OFF;
         cnt_q   <= '0;
         pidx_q  <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         pidx_q  <= pidx_d;
      end
   end

   assign sd_o     = (phase_q == PS_OFF);
   assign emit_o   = (phase_q == PS_HIGH);
   assign sample_o = (phase_q == PS_GAP) && (cnt_q == '0);

   AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (sd_o && !emit_o)); // R6

   AST_FAULT_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |-> (sd_o && !emit_o)); // R8

   AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
      trip_i |=> !emit_o); // R7

endmodule

// File: rtl/prox_burst_ctrl.sv
module prox_burst_ctrl
   import prox_burst_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 10_000_000,
   parameter int unsigned SETTLE_US   = 25,
   parameter int unsigned PULSES      = 50,
   parameter int unsigned PERIOD_US   = 100,
   parameter int unsigned HIGH_US     = 50,
   parameter int unsigned WDOG_US     = 80,
   parameter int unsigned INTERVAL_US = 1_000_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fault_clr,
   input  logic det_n,
   output logic sensor_sd,
   output logic emit,
   output logic present,
   output logic burst_done,
   output logic fault
);

   if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
      $error("prox_burst_ctrl: CLK_HZ must be a whole number of MHz");
   end
   if (SETTLE_US < 20) begin : g_bad_settle
      $error("prox_burst_ctrl: SETTLE_US must be at least 20");
   end
   if (WDOG_US < 1 || WDOG_US >= 85) begin : g_bad_wdog
      $error("prox_burst_ctrl: WDOG_US must lie in 1..84");
   end
   if (HIGH_US < 1 || PERIOD_US <= HIGH_US) begin : g_bad_period
      $error("prox_burst_ctrl: need 1 <= HIGH_US < PERIOD_US");
   end
   if (PULSES < 1) begin : g_bad_pulses
      $error("prox_burst_ctrl: PULSES must be at least 1");
   end
   if (INTERVAL_US <= (PULSES - 1) * PERIOD_US + HIGH_US) begin : g_bad_interval
      $error("prox_burst_ctrl: INTERVAL_US must exceed the burst length");
   end

   localparam int unsigned SET_C   = us_to_cycles(SETTLE_US, CLK_HZ);
   localparam int unsigned HI_C    = us_to_cycles(HIGH_US, CLK_HZ);
   localparam int unsigned LO_C    = us_to_cycles(PERIOD_US - HIGH_US, CLK_HZ);
   localparam int unsigned WD_C    = us_to_cycles(WDOG_US, CLK_HZ);
   localparam int unsigned IV_C    = us_to_cycles(INTERVAL_US, CLK_HZ);
   localparam int unsigned BURST_C = us_to_cycles((PULSES - 1) * PERIOD_US + HIGH_US, CLK_HZ);
   localparam int unsigned GAP_C   = IV_C - BURST_C;

   logic det_s;
   logic trip;
   logic sample_stb;
   logic present_q;
   logic done_q;

   prox_det_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (det_n),
      .q_o   (det_s)
   );

   prox_pulse_wdog #(
      .LIMIT_CYC (WD_C)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .emit_i  (emit),
      .clr_i   (fault_clr),
      .trip_o  (trip),
      .fault_o (fault)
   );

   prox_burst_seq #(
      .SET_C  (SET_C),
      .HI_C   (HI_C),
      .LO_C   (LO_C),
      .GAP_C  (GAP_C),
      .PULSES (PULSES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en),
      .fault_i  (fault),
      .trip_i   (trip),
      .sd_o     (sensor_sd),
      .emit_o   (emit),
      .sample_o (sample_stb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= sample_stb;
         if (sample_stb) present_q <= ~det_s;
      end
   end

   assign present    = present_q;
   assign burst_done = done_q;

   AST_PRESENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(present) |-> burst_done); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |=> !burst_done); // R5

   AST_NO_EMIT_IN_SD: assert property (@(posedge clk) disable iff (!rst_n)
      emit |-> !sensor_sd); // R2

   AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_done) |-> ($past(emit, 2) && !$past(emit))); // R5

endmodule

// File: tb/sim_prox_burst_ctrl.sv
module sim_prox_burst_ctrl;

   localparam int CLK_PERIOD = 10;

   // main configuration: 1 MHz model clock, one cycle per microsecond
   localparam int A_SET = 25, A_PUL = 4, A_PER = 10, A_HI = 5, A_WD = 8, A_IV = 100;
   // watchdog configuration: pulse longer than the limit
   localparam int B_SET = 20, B_PUL = 2, B_PER = 14, B_HI = 9, B_WD = 6, B_IV = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, clr = 1'b0, det_n = 1'b1;
   logic en1 = 1'b0, clr1 = 1'b0;
   logic sd, emit, present, done, fault;
   logic sd1, emit1, present1, done1, fault1;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_on = 1'b0;
   bit any_fault_a = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prox_burst_ctrl #(
      .CLK_HZ(1_000_000), .SETTLE_US(A_SET), .PULSES(A_PUL), .PERIOD_US(A_PER),
      .HIGH_US(A_HI), .WDOG_US(A_WD), .INTERVAL_US(A_IV), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .fault_clr(clr), .det_n(det_n),
      .sensor_sd(sd), .emit(emit), .present(present), .burst_done(done), .fault(fault)
   );

   prox_burst_ctrl #(
      .CLK_HZ(1_000_000), .SETTLE_US(B_SET), .PULSES(B_PUL), .PERIOD_US(B_PER),
      .HIGH_US(B_HI), .WDOG_US(B_WD), .INTERVAL_US(B_IV), .SYNC_STAGES(2)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .en(en1), .fault_clr(clr1), .det_n(1'b1),
      .sensor_sd(sd1), .emit(emit1), .present(present1), .burst_done(done1), .fault(fault1)
   );

   function automatic logic exp_presence(input logic d);
      return ~d;
   endfunction

   function automatic int low_gap(input int per, input int hi);
      return per - hi;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // monitor of the main instance, sampled at the falling edge
   int cyc = 0, sd_fall = 0, rise_c = 0, fall_c = 0, bstart = 0, npul = 0, pend = -1;
   bit first = 1'b1;
   logic emit_p = 1'b0, sd_p = 1'b1, pres_p = 1'b0;

   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (fault) any_fault_a = 1'b1;
         if (!sd && sd_p) sd_fall = cyc;
         if (sd) begin
            first = 1'b1;
            npul  = 0;
            pend  = -1;
         end else begin
            if (emit && !emit_p) begin
               if (first) begin
                  chk(cyc - sd_fall == A_SET, "R2 settle", cyc - sd_fall, A_SET);
                  first  = 1'b0;
                  bstart = cyc;
               end else if (npul == 0) begin
                  chk(cyc - bstart == A_IV, "R4 interval", cyc - bstart, A_IV);
                  bstart = cyc;
               end else begin
                  chk(cyc - fall_c == low_gap(A_PER, A_HI), "R3 low gap",
                      cyc - fall_c, low_gap(A_PER, A_HI));
               end
               rise_c = cyc;
            end
            if (!emit && emit_p) begin
               chk(cyc - rise_c == A_HI, "R3 high width", cyc - rise_c, A_HI);
               fall_c = cyc;
               npul++;
               if (npul == A_PUL) begin
                  npul = 0;
                  pend = cyc + 1;
               end
            end
         end
         if (cyc == pend) begin
            chk(done == 1'b1, "R5 done strobe", int'(done), 1);
            chk(present == exp_presence(det_n), "R5 presence value",
                int'(present), int'(exp_presence(det_n)));
         end else begin
            chk(done == 1'b0, "R5 no stray done", int'(done), 0);
            chk(present == pres_p, "R5 presence held", int'(present), int'(pres_p));
         end
         emit_p = emit;
         sd_p   = sd;
         pres_p = present;
      end
   end

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      // R1 reset state
      repeat (4) @(negedge clk);
      chk(sd && !emit && !present && !done && !fault, "R1 reset outputs",
          {sd, emit, present, done, fault}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sd && !emit && !present && !done && !fault, "R1 after release",
          {sd, emit, present, done, fault}, 5'b10000);
      mon_on = 1'b1;
      // R2 enable gating
      repeat (12) @(negedge clk);
      chk(sd && !emit, "R2 disabled stays down", {sd, emit}, 2'b10);
      det_n = 1'b0;
      en = 1'b1;
      @(negedge clk);
      chk(!sd, "R2 shutdown released", int'(sd), 0);

      // random detect patterns, with toggles in the middle of each burst
      for (int b = 0; b < 10; b++) begin
         wait_done();
         repeat (2 + ($urandom % 50)) @(negedge clk);
         det_n = 1'($urandom);
         wait (1);
         repeat (5) @(negedge clk);
         det_n = 1'($urandom);
         repeat (8) @(negedge clk);
         det_n = 1'($urandom);
      end
      wait_done();
      // directed: object present then absent
      repeat (20) @(negedge clk);
      det_n = 1'b0;
      wait_done();
      chk(present == 1'b1, "R5 object near", int'(present), 1);
      repeat (20) @(negedge clk);
      det_n = 1'b1;
      wait_done();
      chk(present == 1'b0, "R5 object gone", int'(present), 0);

      // R6 aborts at random points inside pulses
      for (int a = 0; a < 4; a++) begin
         repeat ($urandom % 60) @(negedge clk);
         do @(negedge clk); while (!emit);
         repeat ($urandom % 3) @(negedge clk);
         en = 1'b0;
         @(negedge clk);
         chk(sd && !emit, "R6 abort", {sd, emit}, 2'b10);
         repeat (1 + ($urandom % 20)) @(negedge clk);
         chk(sd && !emit && !done, "R6 stays off", {sd, emit, done}, 3'b100);
         en = 1'b1;
         wait_done();
      end
      chk(any_fault_a == 1'b0, "R7 short pulses no fault", int'(any_fault_a), 0);

      // R7 and R8 on the watchdog configuration
      en1 = 1'b1;
      do @(negedge clk); while (!emit1);
      begin
         int w;
         w = 0;
         while (emit1) begin
            w++;
            @(negedge clk);
         end
         chk(w == B_WD, "R7 cut width", w, B_WD);
      end
      chk(fault1 && sd1, "R7 fault and shutdown", {fault1, sd1}, 2'b11);
      repeat (30) @(negedge clk);
      chk(fault1 && sd1 && !emit1, "R8 fault holds with enable",
          {fault1, sd1, emit1}, 3'b110);
      clr1 = 1'b1;
      @(negedge clk);
      clr1 = 1'b0;
      chk(!fault1, "R8 clear", int'(fault1), 0);
      @(negedge clk);
      chk(!sd1, "R8 release after clear", int'(sd1), 0);
      en1 = 1'b0;
      repeat (3) @(negedge clk);

      mon_on = 1'b0;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule